// File: doc/BRIEF.md
# Shutdown Wake-Up and Reset-Cause Controller

This block runs on the always-on clock and handles the exit from a deep shutdown state, in which the core supply is switched off. Software asks for shutdown with a sleep request. The controller then holds the core in reset and turns the regulator enable off. Three kinds of event can bring the device back:

- a low level on the wake pin,
- a low level on the external reset pin,
- an enabled event pulse from the always-on timer.

On a wake the controller turns the regulator enable on again. It keeps the core in reset until core power is reported valid. After a wake through the reset pin, it also waits until that pin has returned high.

A small reset-cause register lets software tell a cold power-on apart from a wake out of shutdown, and also shows a wake through the reset pin. Software clears its bits by writing ones. An early-wake enable decides what happens when the wake pin is already low at the moment shutdown is requested. By default the low pin is ignored. With the enable set, the request is cancelled and execution simply continues.

Top module: `shutdown_wake_ctrl`

## Requirements
- R1: While and after the power-on reset `porRstN` is low, the cause register reads 3'b001 (bit 0 = power-on, bit 1 = shutdown wake, bit 2 = reset-pin wake), `regulatorEn` is 1, `pwrTimeoutErr` is 0, and `coreRstN` stays 0 until `corePwrValid` is 1 with the reset pin high.
- R2: A one-cycle `sleepReq` (early-wake not taking effect) leaves `regulatorEn` at 1 one cycle later, drives it to 0 two cycles later, and forces `coreRstN` to 0.
- R3: In shutdown, a low level on the wake pin, once seen by the two-flop synchronizer, turns `regulatorEn` back on.
- R4: With `earlyWakeEn` = 0, a wake pin that is already low when shutdown is entered does not wake the device. The pin must first be seen high during shutdown and then go low.
- R5: With `earlyWakeEn` = 1 and the synchronized wake pin low at the sleep request, shutdown is not entered. `regulatorEn` and `coreRstN` stay 1, `sleepResume` pulses for one cycle, and the cause register keeps its value.
- R6: Timer events (`tmrEvt` bit 0 alarm, bit 1 periodic, bit 2 overflow) wake the device on the following edge only when the matching `tmrEn` bit is 1. A disabled event leaves `regulatorEn` at 0.
- R7: After a wake the core stays in reset while `corePwrValid` is 0. It is released within three cycles of `corePwrValid` becoming 1.
- R8: A wake through the external reset pin keeps `coreRstN` at 0 while the pin stays low, even with power valid, and sets cause bit 2.
- R9: Every wake out of shutdown sets cause bit 1.
- R10: A one-cycle `causeClr` clears exactly the cause bits written as one on the next edge. A set in the same cycle wins over the clear.
- R11: If `corePwrValid` stays 0 for `PWR_TIMEOUT` (1024) cycles after a wake, `pwrTimeoutErr` rises and stays set until the next power-on reset. The core stays in reset even if power later becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| wakePinN | input | 1 | Wake pin, active low, asynchronous |
| extRstPinN | input | 1 | External reset pin, active low, asynchronous |
| tmrEvt | input | 3 | Timer event pulses: alarm, periodic, overflow |
| tmrEn | input | 3 | Per-event wake enables |
| earlyWakeEn | input | 1 | Lets a low wake pin cancel a shutdown request |
| sleepReq | input | 1 | Shutdown request from software |
| corePwrValid | input | 1 | Core supply reported valid |
| causeClr | input | 3 | Write-one-to-clear strobe for the cause bits |
| regulatorEn | output | 1 | Core regulator enable |
| coreRstN | output | 1 | Core reset, active low |
| sleepResume | output | 1 | One-cycle pulse when a request is cancelled |
| pwrTimeoutErr | output | 1 | Sticky power-valid timeout flag |
| rstCause | output | 3 | Reset-cause register |

## Verification
Waking is tried from each of the three source kinds. The timer path is walked through a table that pairs every event with its enable both set and cleared, so that a missing gate or a swapped bit shows up as a wake that should not happen, or a missing one. The wake pin is tried low before entry with the early enable off and on. This separates the ignore, cancel and normal-wake behaviours. A reset-pin wake held low with power valid separates "power valid" from "release allowed". A power supply that never becomes valid checks the timeout and confirms that it cannot be escaped.

// File: rtl/swk_pkg.sv
package swk_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_SHUTDOWN,
    ST_POWER_UP,
    ST_HOLD_RESET,
    ST_RELEASE
  } swkState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrArm;    // forget any earlier high level of the wake pin
    logic watchArm;  // in shutdown: learn that the wake pin has been high
    logic setSleep;  // record a wake out of shutdown
    logic setExt;    // record that the reset pin caused the wake
    logic cntClr;    // restart the power-valid wait counter
    logic cntEn;     // advance the power-valid wait counter
    logic setErr;    // raise the sticky timeout flag
  } swkStrobe_t;

  localparam int CAUSE_W     = 3;
  localparam int CAUSE_POR   = 0;
  localparam int CAUSE_SLEEP = 1;
  localparam int CAUSE_EXT   = 2;
  localparam int TMR_W       = 3;

endpackage

// File: rtl/swk_datapath.sv
module swk_datapath
  import swk_pkg::*;
#(
  parameter int PWR_TIMEOUT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               wakePinN,
  input  logic               extRstPinN,
  input  logic [TMR_W-1:0]   tmrEvt,
  input  logic [TMR_W-1:0]   tmrEn,
  input  logic [CAUSE_W-1:0] causeClr,
  input  swkStrobe_t         strobe,
  output logic               wakeLow,
  output logic               rstLow,
  output logic               wakeArmed,
  output logic               timerHit,
  output logic               timeout,
  output logic               err,
  output logic [CAUSE_W-1:0] cause
);

  localparam int NUM_PINS = 2;
  localparam int CNT_W    = $clog2(PWR_TIMEOUT) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWR_TIMEOUT - 1);

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinSync;
  logic [CNT_W-1:0]    waitCnt;

  assign pinRaw = {extRstPinN, wakePinN};

  // Synchronizer chain per asynchronous pin; idle level is high
  for (genvar g = 0; g < NUM_PINS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] syncQ;
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) syncQ <= '1;
      else          syncQ <= {syncQ[SYNC_STAGES-2:0], pinRaw[g]};
    end
    assign pinSync[g] = syncQ[SYNC_STAGES-1];
  end

  assign wakeLow  = !pinSync[0];
  assign rstLow   = !pinSync[1];
  assign timerHit = |(tmrEvt & tmrEn);
  assign timeout  = (waitCnt == CNT_LAST);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)             wakeArmed <= 1'b0;
    else if (strobe.clrArm)   wakeArmed <= 1'b0;
    else if (strobe.watchArm && !wakeLow) wakeArmed <= 1'b1;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                         waitCnt <= '0;
    else if (strobe.cntClr)               waitCnt <= '0;
    else if (strobe.cntEn && !timeout)    waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)          err <= 1'b0;
    else if (strobe.setErr) err <= 1'b1;
  end

  // Cause register: power-on sets bit 0 only; W1C clear, set has priority
  logic [CAUSE_W-1:0] causeSet;
  always_comb begin
    causeSet              = '0;
    causeSet[CAUSE_SLEEP] = strobe.setSleep;
    causeSet[CAUSE_EXT]   = strobe.setExt;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) cause <= CAUSE_W'(1) << CAUSE_POR;
    else          cause <= (cause & ~causeClr) | causeSet;
  end

  assert_sleep_cause_R9: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.setSleep |=> cause[CAUSE_SLEEP]);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!porRstN)
    err |=> err);

  assert_arm_cleared_R4: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(wakeArmed) |-> $past(strobe.clrArm));

endmodule

// File: rtl/swk_ctrl.sv
module swk_ctrl
  import swk_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       sleepReq,
  input  logic       earlyWakeEn,
  input  logic       corePwrValid,
  input  logic       wakeLow,
  input  logic       rstLow,
  input  logic       wakeArmed,
  input  logic       timerHit,
  input  logic       timeout,
  input  logic       err,
  output swkStrobe_t strobe,
  output logic       regulatorEn,
  output logic       coreRstN,
  output logic       sleepResume
);

  swkState_e state, stateNxt;
  logic cancelReq;
  logic wakeNow;

  assign cancelReq = sleepReq && earlyWakeEn && wakeLow;
  assign wakeNow   = (wakeLow && wakeArmed) || rstLow || timerHit;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:        if (sleepReq && !cancelReq) stateNxt = ST_ENTER;
      ST_ENTER:      stateNxt = ST_SHUTDOWN;
      ST_SHUTDOWN:   if (wakeNow) stateNxt = ST_POWER_UP;
      ST_POWER_UP:   if (!err && corePwrValid) stateNxt = ST_HOLD_RESET;
      ST_HOLD_RESET: if (corePwrValid && !rstLow) stateNxt = ST_RELEASE;
      ST_RELEASE:    stateNxt = ST_RUN;
      default:       stateNxt = ST_HOLD_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state       <= ST_HOLD_RESET;
      sleepResume <= 1'b0;
    end else begin
      state       <= stateNxt;
      sleepResume <= (state == ST_RUN) && cancelReq;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clrArm   = (state == ST_ENTER);
    strobe.watchArm = (state == ST_SHUTDOWN);
    strobe.setSleep = (state == ST_SHUTDOWN) && wakeNow;
    strobe.setExt   = (state == ST_SHUTDOWN) && wakeNow && rstLow;
    strobe.cntClr   = (state == ST_SHUTDOWN) && wakeNow;
    strobe.cntEn    = (state == ST_POWER_UP);
    strobe.setErr   = (state == ST_POWER_UP) && !err && !corePwrValid && timeout;
  end

  assign regulatorEn = (state != ST_SHUTDOWN);
  assign coreRstN    = (state == ST_RUN);

  assert_release_power_R7: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(coreRstN) |-> $past(corePwrValid, 2) && !$past(rstLow, 2));

  assert_off_after_req_R2: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(regulatorEn) |-> $past(sleepReq, 2));

  assert_resume_enabled_R5: assert property (@(posedge clk) disable iff (!porRstN)
    sleepResume |-> $past(earlyWakeEn) && regulatorEn && coreRstN);

  assert_no_release_on_err_R11: assert property (@(posedge clk) disable iff (!porRstN)
    err |-> !coreRstN);

endmodule

// File: rtl/shutdown_wake_ctrl.sv
module shutdown_wake_ctrl
  import swk_pkg::*;
#(
  parameter int PWR_TIMEOUT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               wakePinN,
  input  logic               extRstPinN,
  input  logic [TMR_W-1:0]   tmrEvt,
  input  logic [TMR_W-1:0]   tmrEn,
  input  logic               earlyWakeEn,
  input  logic               sleepReq,
  input  logic               corePwrValid,
  input  logic [CAUSE_W-1:0] causeClr,
  output logic               regulatorEn,
  output logic               coreRstN,
  output logic               sleepResume,
  output logic               pwrTimeoutErr,
  output logic [CAUSE_W-1:0] rstCause
);

  swkStrobe_t strobe;
  logic wakeLow, rstLow, wakeArmed, timerHit, timeout;

  swk_ctrl u_ctrl (
    .clk          (clk),
    .porRstN      (porRstN),
    .sleepReq     (sleepReq),
    .earlyWakeEn  (earlyWakeEn),
    .corePwrValid (corePwrValid),
    .wakeLow      (wakeLow),
    .rstLow       (rstLow),
    .wakeArmed    (wakeArmed),
    .timerHit     (timerHit),
    .timeout      (timeout),
    .err          (pwrTimeoutErr),
    .strobe       (strobe),
    .regulatorEn  (regulatorEn),
    .coreRstN     (coreRstN),
    .sleepResume  (sleepResume)
  );

  swk_datapath #(
    .PWR_TIMEOUT (PWR_TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .wakePinN   (wakePinN),
    .extRstPinN (extRstPinN),
    .tmrEvt     (tmrEvt),
    .tmrEn      (tmrEn),
    .causeClr   (causeClr),
    .strobe     (strobe),
    .wakeLow    (wakeLow),
    .rstLow     (rstLow),
    .wakeArmed  (wakeArmed),
    .timerHit   (timerHit),
    .timeout    (timeout),
    .err        (pwrTimeoutErr),
    .cause      (rstCause)
  );

endmodule

// File: tb/shutdown_wake_ctrl_tb.sv
`timescale 1ns/1ps
module shutdown_wake_ctrl_tb;

  logic clk = 1'b0;
  logic porRstN, wakePinN, extRstPinN, earlyWakeEn, sleepReq, corePwrValid;
  logic [2:0] tmrEvt, tmrEn, causeClr;
  logic regulatorEn, coreRstN, sleepResume, pwrTimeoutErr;
  logic [2:0] rstCause;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shutdown_wake_ctrl u_dut (
    .clk(clk), .porRstN(porRstN), .wakePinN(wakePinN), .extRstPinN(extRstPinN),
    .tmrEvt(tmrEvt), .tmrEn(tmrEn), .earlyWakeEn(earlyWakeEn), .sleepReq(sleepReq),
    .corePwrValid(corePwrValid), .causeClr(causeClr), .regulatorEn(regulatorEn),
    .coreRstN(coreRstN), .sleepResume(sleepResume), .pwrTimeoutErr(pwrTimeoutErr),
    .rstCause(rstCause)
  );

  // {tmrEvt, tmrEn, expectWake}
  localparam logic [6:0] TMR_VEC [8] = '{
    {3'b001, 3'b001, 1'b1},
    {3'b010, 3'b010, 1'b1},
    {3'b100, 3'b100, 1'b1},
    {3'b001, 3'b110, 1'b0},
    {3'b010, 3'b101, 1'b0},
    {3'b100, 3'b011, 1'b0},
    {3'b011, 3'b010, 1'b1},
    {3'b111, 3'b000, 1'b0}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic goShutdown();
    sleepReq = 1'b1;
    cyc(1);
    sleepReq = 1'b0;
    cyc(1);
    corePwrValid = 1'b0;
  endtask

  task automatic powerBack();
    cyc(3);
    check("R7 held in reset without power", coreRstN, 1'b0);
    corePwrValid = 1'b1;
    cyc(4);
    check("R7 released after power valid", coreRstN, 1'b1);
  endtask

  task automatic clearCause();
    causeClr = 3'b111;
    cyc(1);
    causeClr = 3'b000;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [2:0] saved;
    porRstN = 1'b0; wakePinN = 1'b1; extRstPinN = 1'b1; earlyWakeEn = 1'b0;
    sleepReq = 1'b0; corePwrValid = 1'b0; tmrEvt = '0; tmrEn = '0; causeClr = '0;
    cyc(3);
    // R1 reset state
    check("R1 cause at por", rstCause, 3'b001);
    check("R1 regulator on", regulatorEn, 1'b1);
    check("R1 core in reset", coreRstN, 1'b0);
    check("R1 no error", pwrTimeoutErr, 1'b0);
    porRstN = 1'b1;
    cyc(4);
    check("R1 waits for power", coreRstN, 1'b0);
    corePwrValid = 1'b1;
    cyc(3);
    check("R1 released", coreRstN, 1'b1);

    // R2 entry timing
    sleepReq = 1'b1;
    cyc(1);
    sleepReq = 1'b0;
    check("R2 regulator still on", regulatorEn, 1'b1);
    check("R2 core in reset", coreRstN, 1'b0);
    cyc(1);
    check("R2 regulator off", regulatorEn, 1'b0);
    corePwrValid = 1'b0;
    cyc(3);
    // R3 wake pin
    wakePinN = 1'b0;
    cyc(1);
    check("R3 sync delay", regulatorEn, 1'b0);
    cyc(3);
    check("R3 wake pin", regulatorEn, 1'b1);
    wakePinN = 1'b1;
    check("R9 sleep cause", rstCause[1], 1'b1);
    powerBack();

    // R10 clear only written bits
    check("R10 before clear", rstCause, 3'b011);
    causeClr = 3'b010;
    cyc(1);
    causeClr = 3'b000;
    check("R10 clear bit1 only", rstCause, 3'b001);
    clearCause();
    check("R10 cleared all", rstCause, 3'b000);

    // R6 timer table
    for (int i = 0; i < 8; i++) begin
      goShutdown();
      cyc(2);
      tmrEn  = TMR_VEC[i][3:1];
      tmrEvt = TMR_VEC[i][6:4];
      cyc(1);
      tmrEvt = '0;
      check($sformatf("R6 timer vector %0d", i), regulatorEn, TMR_VEC[i][0]);
      cyc(3);
      check($sformatf("R6 timer vector %0d settled", i), regulatorEn, TMR_VEC[i][0]);
      if (!TMR_VEC[i][0]) begin
        wakePinN = 1'b0;
        cyc(4);
        wakePinN = 1'b1;
      end
      tmrEn = '0;
      powerBack();
    end
    clearCause();

    // R4 pin low before entry ignored
    wakePinN = 1'b0;
    cyc(3);
    goShutdown();
    cyc(10);
    check("R4 early low ignored", regulatorEn, 1'b0);
    wakePinN = 1'b1;
    cyc(4);
    check("R4 still off after high", regulatorEn, 1'b0);
    wakePinN = 1'b0;
    cyc(4);
    check("R4 wake after re-low", regulatorEn, 1'b1);
    wakePinN = 1'b1;
    powerBack();

    // R5 early-wake cancel
    saved = rstCause;
    earlyWakeEn = 1'b1;
    wakePinN = 1'b0;
    cyc(3);
    sleepReq = 1'b1;
    cyc(1);
    sleepReq = 1'b0;
    check("R5 resume pulse", sleepResume, 1'b1);
    cyc(1);
    check("R5 pulse one cycle", sleepResume, 1'b0);
    cyc(4);
    check("R5 regulator on", regulatorEn, 1'b1);
    check("R5 core running", coreRstN, 1'b1);
    check("R5 cause unchanged", rstCause, saved);
    wakePinN = 1'b1;
    earlyWakeEn = 1'b0;
    cyc(3);
    clearCause();

    // R8 external reset wake
    goShutdown();
    cyc(2);
    extRstPinN = 1'b0;
    cyc(4);
    check("R8 reset pin wakes", regulatorEn, 1'b1);
    corePwrValid = 1'b1;
    cyc(10);
    check("R8 held while pin low", coreRstN, 1'b0);
    check("R8 R9 cause bits", rstCause, 3'b110);
    // R10 set wins over clear: next wake sets while clear is written
    extRstPinN = 1'b1;
    cyc(6);
    check("R8 released after pin high", coreRstN, 1'b1);
    clearCause();
    goShutdown();
    cyc(2);
    tmrEn = 3'b001;
    tmrEvt = 3'b001;
    causeClr = 3'b010;
    cyc(1);
    tmrEvt = '0; tmrEn = '0; causeClr = '0;
    check("R10 set wins", rstCause[1], 1'b1);
    powerBack();
    clearCause();

    // R11 power-valid timeout
    goShutdown();
    cyc(2);
    tmrEn = 3'b100;
    tmrEvt = 3'b100;
    cyc(1);
    tmrEvt = '0; tmrEn = '0;
    cyc(1000);
    check("R11 no error before limit", pwrTimeoutErr, 1'b0);
    cyc(100);
    check("R11 error raised", pwrTimeoutErr, 1'b1);
    corePwrValid = 1'b1;
    cyc(10);
    check("R11 stays in reset", coreRstN, 1'b0);
    check("R11 error sticky", pwrTimeoutErr, 1'b1);

    // R1 power-on reset recovers
    porRstN = 1'b0;
    cyc(2);
    check("R1 cause after por", rstCause, 3'b001);
    check("R1 error cleared", pwrTimeoutErr, 1'b0);
    porRstN = 1'b1;
    cyc(3);
    check("R1 running after por", coreRstN, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule